// File: doc/BRIEF.md
# Fabric Reset Release Sequencer

This block lives on the programmable-fabric side of a device that also contains an embedded processor subsystem. It produces one reset for user application logic. That reset is held until three things are true: the fabric has finished configuration and entered user mode, the processor is out of every kind of reset, and the processor has raised every status bit that a run-time mask selects. Once all of these hold, the block waits a fixed number of clocks and then releases the reset on a clock edge. If any of the hard conditions drops, the reset is asserted again at once, with no clock needed.

The block also answers the processor's warm-reset request. When the active-low pending-request line falls, the block raises a quiesce request to the application. It then returns an active-low acknowledge, either when the application reports that it has drained or when a timeout runs out. The acknowledge stays low until the processor lets go of the request. A watchdog-triggered reset bypasses this exchange completely: the acknowledge is never driven low while the watchdog flag is up.

A two-bit cause register records the kind of the most recent processor reset, so that recovery logic can read it afterwards. All asynchronous inputs are synchronized with two flops before use. There is no streaming data path, so every pin is a plain level signal.

Top module: `fab_rst_seq`

## Requirements
- R1: While `rst_ni` is low and on the first clocks after it rises, `app_rst_o` is 1, `rst_ack_no` is 1, `quiesce_req_o` is 0 and `cause_o` is 0.
- R2: `app_rst_o` falls only when all of the following hold: `cfg_done_ni` is 0, `proc_rst_i` is 0, `proc_wdog_i` is 0, and `(proc_status_i & ready_mask_i) == ready_mask_i`. The fall comes exactly `RELEASE_DLY`+3 rising edges after the last of these conditions becomes true.
- R3: Status bits whose mask bit is 0 have no effect on release. An all-zero mask releases the reset without regard to the status vector.
- R4: `app_rst_o` rises with no clock edge as soon as `rst_ni` goes low, `cfg_done_ni` goes high, `proc_rst_i` goes high or `proc_wdog_i` goes high.
- R5: If a masked status bit drops while the reset is released, `app_rst_o` is 1 again within 3 rising edges.
- R6: When `rst_pend_ni` falls and no watchdog reset is flagged, `quiesce_req_o` is 1 within 3 rising edges. `rst_ack_no` stays 1 until the quiesce completes.
- R7: `rst_ack_no` falls within 3 edges after `quiesce_done_i` rises. If `quiesce_done_i` never rises, it falls `QUIESCE_TMO` edges after the quiesce began.
- R8: Once low, `rst_ack_no` stays low for as long as `rst_pend_ni` is low. Within 4 edges after `rst_pend_ni` rises, `rst_ack_no` is back to 1 and `quiesce_req_o` is back to 0.
- R9: While `proc_wdog_i` is 1, `rst_ack_no` stays 1 even when a pending request arrives.
- R10: `cause_o` encodes 0 = none, 1 = cold, 2 = warm, 3 = watchdog. It is loaded when a processor reset or watchdog flag begins, with priority watchdog over cold over warm. It holds its value through recovery and is cleared only by `rst_ni`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fabric clock |
| rst_ni | input | 1 | Block power-on reset, active low |
| cfg_done_ni | input | 1 | Fabric in user mode when low |
| proc_rst_i | input | 1 | Processor in any reset, active high |
| proc_cold_i | input | 1 | Processor cold reset flag |
| proc_wdog_i | input | 1 | Processor watchdog reset flag |
| proc_status_i | input | 32 | Processor readiness bits, high = ready |
| ready_mask_i | input | 32 | Selects the status bits required for release |
| rst_pend_ni | input | 1 | Warm-reset pending request, active low |
| quiesce_done_i | input | 1 | Application reports it has drained |
| rst_ack_no | output | 1 | Warm-reset acknowledge, active low |
| quiesce_req_o | output | 1 | Asks the application to drain |
| app_rst_o | output | 1 | Reset to application logic, active high |
| cause_o | output | 2 | Last reset cause code |

## Verification
The release gate is driven through a table of combinations of configuration-done, processor reset, watchdog flag, status vector and mask. The table tells a full mask apart from partial masks, a zero mask, a single missing bit at the top or bottom of the vector, and a masked-out bit that is low. Directed sequences measure the exact release latency and check that assertion needs no clock. The handshake is run three ways: completion by the drain signal, completion by timeout, and suppression under a watchdog flag. Cold, warm and watchdog resets are applied in turn, and each one must leave its own code in the cause register.

// File: rtl/fab_rst_seq_pkg.sv
package fab_rst_seq_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_COLD = 2'd1,
    CAUSE_WARM = 2'd2,
    CAUSE_WDOG = 2'd3
  } rst_cause_e;

  typedef enum logic [1:0] {
    HS_IDLE    = 2'd0,
    HS_QUIESCE = 2'd1,
    HS_ACK     = 2'd2
  } hs_state_e;
endpackage

// File: rtl/frs_sync.sv
module frs_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= {W{RST_VAL}};
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/frs_release.sv
module frs_release #(
  parameter int unsigned RELEASE_DLY = 16
) (
  input  logic clk_i,
  input  logic hold_ni,
  input  logic stat_ok_i,
  output logic app_rst_o
);
  localparam int unsigned CW = (RELEASE_DLY > 0) ? $clog2(RELEASE_DLY + 1) : 1;
  localparam logic [CW-1:0] CNT_END = CW'(RELEASE_DLY);

  logic          arm1_q, arm2_q, rel_q;
  logic [CW-1:0] cnt_q;
  logic          cond;

  always_ff @(posedge clk_i or negedge hold_ni) begin
    if (!hold_ni) begin
      arm1_q <= 1'b0;
      arm2_q <= 1'b0;
    end else begin
      arm1_q <= 1'b1;
      arm2_q <= arm1_q;
    end
  end

  assign cond = arm2_q & stat_ok_i;

  always_ff @(posedge clk_i or negedge hold_ni) begin
    if (!hold_ni) begin
      cnt_q <= '0;
      rel_q <= 1'b0;
    end else if (!cond) begin
      cnt_q <= '0;
      rel_q <= 1'b0;
    end else if (cnt_q == CNT_END) begin
      rel_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign app_rst_o = ~rel_q;

  // R2: release only after a cycle in which every condition held
  a_r2_release_gate: assert property (@(posedge clk_i) disable iff (!hold_ni)
    $fell(app_rst_o) |-> $past(arm2_q && stat_ok_i));
  // R5: a missing ready bit re-asserts reset on the next edge
  a_r5_status_drop: assert property (@(posedge clk_i) disable iff (!hold_ni)
    !stat_ok_i |=> app_rst_o);
endmodule

// File: rtl/frs_handshake.sv
module frs_handshake
  import fab_rst_seq_pkg::*;
#(
  parameter int unsigned QUIESCE_TMO = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pend_ns_i,
  input  logic qdone_s_i,
  input  logic wdog_s_i,
  output logic quiesce_req_o,
  output logic rst_ack_no
);
  localparam int unsigned TW = $clog2(QUIESCE_TMO + 1);
  localparam logic [TW-1:0] TMO_LAST = TW'(QUIESCE_TMO - 1);

  hs_state_e     state_q, state_d;
  logic [TW-1:0] tmo_q;

  always_comb begin
    state_d = state_q;
    if (wdog_s_i) begin
      state_d = HS_IDLE;
    end else begin
      unique case (state_q)
        HS_IDLE:    if (!pend_ns_i) state_d = HS_QUIESCE;
        HS_QUIESCE: if (pend_ns_i) state_d = HS_IDLE;
                    else if (qdone_s_i || tmo_q == TMO_LAST) state_d = HS_ACK;
        HS_ACK:     if (pend_ns_i) state_d = HS_IDLE;
        default:    state_d = HS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= HS_IDLE;
      tmo_q   <= '0;
    end else begin
      state_q <= state_d;
      tmo_q   <= (state_q == HS_QUIESCE) ? tmo_q + 1'b1 : '0;
    end
  end

  assign quiesce_req_o = (state_q == HS_QUIESCE) || (state_q == HS_ACK);
  assign rst_ack_no    = (state_q != HS_ACK);

  // R9: no acknowledge while a watchdog reset is flagged
  a_r9_wdog_no_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdog_s_i |=> rst_ack_no);
  // R7: acknowledge is preceded by a quiesce request
  a_r7_ack_after_quiesce: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_ack_no) |-> $past(quiesce_req_o));
  // R8: acknowledge held while the request stays low
  a_r8_ack_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rst_ack_no && !pend_ns_i && !wdog_s_i) |=> !rst_ack_no);
endmodule

// File: rtl/frs_cause.sv
module frs_cause
  import fab_rst_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       prst_s_i,
  input  logic       cold_s_i,
  input  logic       wdog_s_i,
  output logic [1:0] cause_o
);
  logic       prst_prev_q, wdog_prev_q, evt;
  rst_cause_e cause_q;

  assign evt = (prst_s_i & ~prst_prev_q) | (wdog_s_i & ~wdog_prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prst_prev_q <= 1'b0;
      wdog_prev_q <= 1'b0;
      cause_q     <= CAUSE_NONE;
    end else begin
      prst_prev_q <= prst_s_i;
      wdog_prev_q <= wdog_s_i;
      if (evt) begin
        if (wdog_s_i)      cause_q <= CAUSE_WDOG;
        else if (cold_s_i) cause_q <= CAUSE_COLD;
        else               cause_q <= CAUSE_WARM;
      end
    end
  end

  assign cause_o = cause_q;

  // R10: watchdog flag always records the watchdog code
  a_r10_wdog_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wdog_s_i) |=> (cause_o == CAUSE_WDOG));
endmodule

// File: rtl/fab_rst_seq.sv
module fab_rst_seq #(
  parameter int unsigned STAT_W      = 32,
  parameter int unsigned RELEASE_DLY = 16,
  parameter int unsigned QUIESCE_TMO = 1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_done_ni,
  input  logic              proc_rst_i,
  input  logic              proc_cold_i,
  input  logic              proc_wdog_i,
  input  logic [STAT_W-1:0] proc_status_i,
  input  logic [STAT_W-1:0] ready_mask_i,
  input  logic              rst_pend_ni,
  input  logic              quiesce_done_i,
  output logic              rst_ack_no,
  output logic              quiesce_req_o,
  output logic              app_rst_o,
  output logic [1:0]        cause_o
);
  logic [STAT_W-1:0] stat_s;
  logic [3:0]        ctl_s;
  logic              pend_ns;
  logic              hold_n, stat_ok;

  frs_sync #(.W(STAT_W), .RST_VAL(1'b0)) u_stat_sync (
    .clk_i, .rst_ni, .d_i(proc_status_i), .q_o(stat_s));

  frs_sync #(.W(4), .RST_VAL(1'b0)) u_ctl_sync (
    .clk_i, .rst_ni,
    .d_i({quiesce_done_i, proc_wdog_i, proc_cold_i, proc_rst_i}),
    .q_o(ctl_s));

  frs_sync #(.W(1), .RST_VAL(1'b1)) u_pend_sync (
    .clk_i, .rst_ni, .d_i(rst_pend_ni), .q_o(pend_ns));

  assign hold_n  = rst_ni & ~cfg_done_ni & ~proc_rst_i & ~proc_wdog_i;
  assign stat_ok = ((stat_s & ready_mask_i) == ready_mask_i);

  frs_release #(.RELEASE_DLY(RELEASE_DLY)) u_release (
    .clk_i, .hold_ni(hold_n), .stat_ok_i(stat_ok), .app_rst_o);

  frs_handshake #(.QUIESCE_TMO(QUIESCE_TMO)) u_hs (
    .clk_i, .rst_ni, .pend_ns_i(pend_ns), .qdone_s_i(ctl_s[3]),
    .wdog_s_i(ctl_s[2]), .quiesce_req_o, .rst_ack_no);

  frs_cause u_cause (
    .clk_i, .rst_ni, .prst_s_i(ctl_s[0]), .cold_s_i(ctl_s[1]),
    .wdog_s_i(ctl_s[2]), .cause_o);

  // R4: any hard hold condition keeps the application in reset
  a_r4_hold_forces_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_n |-> app_rst_o);
endmodule

// File: tb/fab_rst_seq_tb_top.sv
module fab_rst_seq_tb_top;
  localparam int unsigned DLY = 4;
  localparam int unsigned TMO = 16;

  logic clk = 1'b0;
  logic rst_n, cfg_n, prst, cold, wdog, pend_n, qdone;
  logic [31:0] status, mask;
  logic ack_n, qreq, app_rst;
  logic [1:0] cause;
  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fab_rst_seq #(.STAT_W(32), .RELEASE_DLY(DLY), .QUIESCE_TMO(TMO)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_done_ni(cfg_n), .proc_rst_i(prst),
    .proc_cold_i(cold), .proc_wdog_i(wdog), .proc_status_i(status),
    .ready_mask_i(mask), .rst_pend_ni(pend_n), .quiesce_done_i(qdone),
    .rst_ack_no(ack_n), .quiesce_req_o(qreq), .app_rst_o(app_rst),
    .cause_o(cause));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // {cfg_n, prst, wdog, status, mask, expected app_rst}
  localparam logic [67:0] VEC [10] = '{
    {3'b000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0},
    {3'b000, 32'h0000_FFFF, 32'h0000_FFFF, 1'b0},
    {3'b000, 32'h0000_FFFE, 32'h0000_FFFF, 1'b1},
    {3'b000, 32'h0000_0000, 32'h0000_0000, 1'b0},
    {3'b100, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1},
    {3'b010, 32'h0000_0000, 32'h0000_0000, 1'b1},
    {3'b001, 32'h0000_0000, 32'h0000_0000, 1'b1},
    {3'b000, 32'h8000_0001, 32'h8000_0001, 1'b0},
    {3'b000, 32'h8000_0000, 32'h8000_0001, 1'b1},
    {3'b000, 32'h1234_5678, 32'h0000_0008, 1'b0}
  };

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cfg_n = 1; prst = 0; cold = 0; wdog = 0; pend_n = 1; qdone = 0;
    status = '0; mask = '1;
    #22;
    chk("R1 app_rst in reset", app_rst, 1);
    chk("R1 ack in reset", ack_n, 1);
    chk("R1 quiesce in reset", qreq, 0);
    chk("R1 cause in reset", cause, 0);
    @(negedge clk); rst_n = 1;
    edges(3);
    chk("R1 app_rst after reset", app_rst, 1);

    // table of gate vectors (R2, R3, R4)
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      {cfg_n, prst, wdog, status, mask} = VEC[i][67:1];
      edges(12);
      chk($sformatf("R2/R3 vector %0d", i), app_rst, VEC[i][0]);
    end

    // R2 exact release latency
    @(negedge clk); cfg_n = 1; prst = 0; wdog = 0; status = '1; mask = '1;
    edges(4);
    @(negedge clk); cfg_n = 0;
    edges(DLY + 2);
    chk("R2 still held one edge early", app_rst, 1);
    edges(1);
    chk("R2 released on time", app_rst, 0);

    // R4 asynchronous assertion
    @(negedge clk); prst = 1; #1;
    chk("R4 async assert on proc reset", app_rst, 1);
    prst = 0;
    edges(12);
    @(negedge clk); cfg_n = 1; #1;
    chk("R4 async assert on config", app_rst, 1);
    cfg_n = 0;
    edges(12);
    chk("R2 released again", app_rst, 0);

    // R5 masked status drop
    @(negedge clk); status = 32'hFFFF_FF7F;
    edges(3);
    chk("R5 status drop re-asserts", app_rst, 1);
    @(negedge clk); status = '1;
    edges(12);

    // R6 / R7 / R8 handshake with drain signal
    @(negedge clk); pend_n = 0;
    edges(3);
    chk("R6 quiesce raised", qreq, 1);
    chk("R6 ack not yet", ack_n, 1);
    edges(5);
    chk("R6 ack waits for drain", ack_n, 1);
    @(negedge clk); qdone = 1;
    edges(3);
    chk("R7 ack after drain", ack_n, 0);
    edges(10);
    chk("R8 ack held", ack_n, 0);
    @(negedge clk); pend_n = 1; qdone = 0;
    edges(4);
    chk("R8 ack released", ack_n, 1);
    chk("R8 quiesce released", qreq, 0);

    // R7 timeout path
    edges(4);
    @(negedge clk); pend_n = 0;
    edges(3 + TMO - 2);
    chk("R7 no ack before timeout", ack_n, 1);
    edges(3);
    chk("R7 ack after timeout", ack_n, 0);
    @(negedge clk); pend_n = 1;
    edges(6);
    chk("R8 ack released after timeout", ack_n, 1);

    // R9 watchdog suppresses handshake, R10 watchdog cause
    @(negedge clk); wdog = 1; #1;
    chk("R4 async assert on watchdog", app_rst, 1);
    edges(4);
    @(negedge clk); pend_n = 0;
    edges(30);
    chk("R9 no ack under watchdog", ack_n, 1);
    chk("R10 watchdog cause", cause, 3);
    @(negedge clk); wdog = 0; pend_n = 1;
    edges(12);
    chk("R10 cause kept after recovery", cause, 3);

    // R10 cold and warm causes
    @(negedge clk); prst = 1; cold = 1;
    edges(5);
    chk("R10 cold cause", cause, 1);
    @(negedge clk); prst = 0; cold = 0;
    edges(6);
    @(negedge clk); prst = 1;
    edges(5);
    chk("R10 warm cause", cause, 2);
    @(negedge clk); prst = 0;
    edges(12);
    chk("R2 release after warm reset", app_rst, 0);

    // R1 block reset clears cause
    @(negedge clk); rst_n = 0; #1;
    chk("R1 cause cleared", cause, 0);
    chk("R1 app_rst on block reset", app_rst, 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule